// File: doc/BRIEF.md
# Mirrored Word Store Redundancy Manager

This block connects one processor-side request port to a row of identical storage modules. Each module holds words of 26 data bits. A word is kept as two 13-bit syllables, and each syllable carries its own parity bit. A configuration bit chooses between two ways of using the modules. In single-copy mode every module is addressed on its own, so the whole row gives its full capacity. In mirrored mode, modules are grouped in pairs. Every word is then written into both modules of a pair, which halves the usable capacity. On a mirrored read, the copy whose parity is intact is the one returned.

A request is one cycle of `req` carrying the address, the write enable and the write data. Every request, whether a read, a write or a rejected address, gets exactly one response two clock edges later. The response reports the read data together with a corrected flag, an uncorrectable flag or an address-fault flag. A write-side parity inversion input allows stored words to carry deliberately broken parity, which is how degraded copies are produced in test.

Top module: `mirror_mem_mgr`

## Requirements
- R1: In single-copy mode, address bits [11:9] select the module and bits [8:0] select the word. A write updates only that module. A later read of the same address returns the written data.
- R2: In mirrored mode, address bits [10:9] give the pair index k, which covers modules 2k and 2k+1, and bits [8:0] give the word. A write stores the same code word into both modules on the same clock edge, so either module can later be read back through single-copy mode at word address {module, word}.
- R3: The stored code word is {ph, hi[12:0], pl, lo[12:0]}, where lo is data[12:0] and hi is data[25:13]. Parity is odd for each syllable together with its parity bit. `wr_par_inv[0]` inverts pl and `wr_par_inv[1]` inverts ph. A parity failure in either syllable marks the whole copy bad.
- R4: A mirrored read whose primary copy (module 2k) passes parity returns the primary data with no error flag, whatever the state of the secondary copy.
- R5: A mirrored read whose primary copy fails and whose secondary copy (module 2k+1) passes returns the secondary data and raises `err_corr` for that response only.
- R6: A mirrored read whose two copies both fail raises `err_uncorr` and returns the primary copy's data bits.
- R7: A single-copy read that fails parity raises `err_uncorr`, never raises `err_corr`, and still returns the stored data bits.
- R8: An address that falls outside the populated modules gets `rsp_fault`, `rd_data` of zero, no error flags, and no module write. In single-copy mode that means a module index of `N_MOD` or more. In mirrored mode it means bit 11 is set, or module 2k+1 is `N_MOD` or more.
- R9: `duplex_active` follows `cfg_duplex` only on an edge where no request is presented and none is in flight. A change requested during an access waits until that access completes. The access in flight is decoded in the mode it started in.
- R10: Each request produces one `rsp_valid` pulse exactly two edges after the edge that sampled it. A write response carries `rd_data` of zero and no error flags.
- R11: After reset the block is in single-copy mode and all response outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_duplex | input | 1 | Requested mode: 1 mirrored, 0 single-copy |
| req | input | 1 | Request strobe, one access per cycle |
| we | input | 1 | 1 for write, 0 for read |
| addr | input | 12 | Word address |
| wdata | input | 26 | Write data |
| wr_par_inv | input | 2 | Per-syllable parity inversion on write |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Address outside populated modules |
| rd_data | output | 26 | Read data |
| err_corr | output | 1 | Secondary copy used after primary parity failure |
| err_uncorr | output | 1 | No good copy available |
| duplex_active | output | 1 | Mode currently in force |

## Verification
The assertions take three things for granted. First, `req` is low while reset is held. Second, the mode register changes only on edges where no access is present. Third, the write-enable decode sees a settled address and mode in the cycle of the request. The stimulus keeps within these assumptions by driving every input on the falling edge. It issues requests as single-cycle pulses with idle gaps, except in one directed case that deliberately overlaps a mode change with an access. It changes `cfg_duplex` only through a dedicated idle step. Random addresses span the full 12-bit range so that faulting module and pair indexes occur. Word offsets are limited to a small window that is preloaded first, so reads never see uninitialised storage.

// File: rtl/mirmem_pkg.sv
package mirmem_pkg;
  localparam int SYL_W  = 13;
  localparam int DATA_W = 2 * SYL_W;
  localparam int CODE_W = DATA_W + 2;

  // code word layout: {par_hi, syl_hi, par_lo, syl_lo}, odd parity per syllable
  function automatic logic [CODE_W-1:0] encode(input logic [DATA_W-1:0] d,
                                               input logic [1:0] inv);
    logic [SYL_W-1:0] lo, hi;
    lo = d[SYL_W-1:0];
    hi = d[DATA_W-1:SYL_W];
    return {(~^hi) ^ inv[1], hi, (~^lo) ^ inv[0], lo};
  endfunction

  function automatic logic copy_ok(input logic [CODE_W-1:0] c);
    return (^c[SYL_W:0]) & (^c[CODE_W-1:SYL_W+1]);
  endfunction

  function automatic logic [DATA_W-1:0] payload(input logic [CODE_W-1:0] c);
    return {c[CODE_W-2:SYL_W+1], c[SYL_W-1:0]};
  endfunction
endpackage

// File: rtl/mm_bank.sv
module mm_bank #(
  parameter int AW = 9,
  parameter int W  = 28
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  // single port, read-before-write, registered output: block RAM template
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/mm_decode.sv
module mm_decode #(
  parameter int N_MOD  = 6,
  parameter int SEL_W  = 3,
  parameter int MOD_AW = 9
) (
  input  logic                    req,
  input  logic                    we,
  input  logic                    duplex,
  input  logic [SEL_W+MOD_AW-1:0] addr,
  output logic                    fault,
  output logic [SEL_W-1:0]        prim,
  output logic [MOD_AW-1:0]       word,
  output logic [N_MOD-1:0]        bank_we
);
  localparam int ADDR_W = SEL_W + MOD_AW;

  logic [SEL_W-1:0] sel;

  always_comb begin
    sel  = addr[ADDR_W-1:MOD_AW];
    word = addr[MOD_AW-1:0];
    if (duplex) begin
      prim  = {sel[SEL_W-2:0], 1'b0};
      fault = sel[SEL_W-1] | ((int'(prim) + 1) >= N_MOD);
    end else begin
      prim  = sel;
      fault = int'(sel) >= N_MOD;
    end
  end

  for (genvar i = 0; i < N_MOD; i++) begin : g_we
    always_comb begin
      bank_we[i] = req & we & ~fault &
                   ((int'(prim) == i) | (duplex & ((int'(prim) + 1) == i)));
    end
  end
endmodule

// File: rtl/mm_select.sv
module mm_select
  import mirmem_pkg::*;
#(
  parameter int N_MOD = 6,
  parameter int SEL_W = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         s1_v,
  input  logic                         s1_we,
  input  logic                         s1_fault,
  input  logic                         s1_dup,
  input  logic [SEL_W-1:0]             s1_prim,
  input  logic [N_MOD-1:0][CODE_W-1:0] bank_q,
  output logic                         rsp_valid,
  output logic                         rsp_fault,
  output logic [DATA_W-1:0]            rd_data,
  output logic                         err_corr,
  output logic                         err_uncorr
);
  logic [CODE_W-1:0] q_p, q_s;
  logic              ok_p, ok_s, rd;

  always_comb begin
    q_p = '0;
    q_s = '0;
    for (int i = 0; i < N_MOD; i++) begin
      if (int'(s1_prim) == i)     q_p = bank_q[i];
      if (int'(s1_prim) + 1 == i) q_s = bank_q[i];
    end
    ok_p = copy_ok(q_p);
    ok_s = copy_ok(q_s);
    rd   = s1_v & ~s1_we & ~s1_fault;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_fault  <= 1'b0;
      rd_data    <= '0;
      err_corr   <= 1'b0;
      err_uncorr <= 1'b0;
    end else begin
      rsp_valid  <= s1_v;
      rsp_fault  <= s1_v & s1_fault;
      rd_data    <= '0;
      err_corr   <= 1'b0;
      err_uncorr <= 1'b0;
      if (rd) begin
        if (!s1_dup) begin
          rd_data    <= payload(q_p);
          err_uncorr <= ~ok_p;
        end else if (ok_p) begin
          rd_data <= payload(q_p);
        end else if (ok_s) begin
          rd_data  <= payload(q_s);
          err_corr <= 1'b1;
        end else begin
          rd_data    <= payload(q_p);
          err_uncorr <= 1'b1;
        end
      end
    end
  end

  // R5: a correction only ever follows a mirrored read
  p_corr_dup_only_r5: assert property (@(posedge clk) disable iff (rst)
    err_corr |-> $past(s1_dup) && !err_uncorr);
  // R7: single-copy reads never report a correction
  p_simplex_no_corr_r7: assert property (@(posedge clk) disable iff (rst)
    (s1_v && !s1_dup) |=> !err_corr);
  // R8: faulted responses carry no data and no error flags
  p_fault_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> (rd_data == '0) && !err_corr && !err_uncorr && rsp_valid);
endmodule

// File: rtl/mirror_mem_mgr.sv
module mirror_mem_mgr
  import mirmem_pkg::*;
#(
  parameter int N_MOD  = 6,
  parameter int SEL_W  = 3,
  parameter int MOD_AW = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_duplex,
  input  logic                    req,
  input  logic                    we,
  input  logic [SEL_W+MOD_AW-1:0] addr,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [1:0]              wr_par_inv,
  output logic                    rsp_valid,
  output logic                    rsp_fault,
  output logic [DATA_W-1:0]       rd_data,
  output logic                    err_corr,
  output logic                    err_uncorr,
  output logic                    duplex_active
);
  logic                         dec_fault;
  logic [SEL_W-1:0]             dec_prim;
  logic [MOD_AW-1:0]            dec_word;
  logic [N_MOD-1:0]             bank_we;
  logic [N_MOD-1:0][CODE_W-1:0] bank_q;
  logic [CODE_W-1:0]            wcode;

  logic             s1_v, s1_we, s1_fault, s1_dup;
  logic [SEL_W-1:0] s1_prim;

  // mode register: moves only when nothing is presented or in flight
  always_ff @(posedge clk) begin
    if (rst)                duplex_active <= 1'b0;
    else if (!req && !s1_v) duplex_active <= cfg_duplex;
  end

  mm_decode #(.N_MOD(N_MOD), .SEL_W(SEL_W), .MOD_AW(MOD_AW)) u_dec (
    .req     (req),
    .we      (we),
    .duplex  (duplex_active),
    .addr    (addr),
    .fault   (dec_fault),
    .prim    (dec_prim),
    .word    (dec_word),
    .bank_we (bank_we)
  );

  always_comb wcode = encode(wdata, wr_par_inv);

  for (genvar i = 0; i < N_MOD; i++) begin : g_bank
    mm_bank #(.AW(MOD_AW), .W(CODE_W)) u_bank (
      .clk   (clk),
      .we    (bank_we[i]),
      .addr  (dec_word),
      .wdata (wcode),
      .rdata (bank_q[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v     <= 1'b0;
      s1_we    <= 1'b0;
      s1_fault <= 1'b0;
      s1_dup   <= 1'b0;
      s1_prim  <= '0;
    end else begin
      s1_v     <= req;
      s1_we    <= we;
      s1_fault <= dec_fault;
      s1_dup   <= duplex_active;
      s1_prim  <= dec_prim;
    end
  end

  mm_select #(.N_MOD(N_MOD), .SEL_W(SEL_W)) u_sel (
    .clk        (clk),
    .rst        (rst),
    .s1_v       (s1_v),
    .s1_we      (s1_we),
    .s1_fault   (s1_fault),
    .s1_dup     (s1_dup),
    .s1_prim    (s1_prim),
    .bank_q     (bank_q),
    .rsp_valid  (rsp_valid),
    .rsp_fault  (rsp_fault),
    .rd_data    (rd_data),
    .err_corr   (err_corr),
    .err_uncorr (err_uncorr)
  );

  // R1: a valid single-copy write touches exactly one module
  p_simplex_one_bank_r1: assert property (@(posedge clk) disable iff (rst)
    (req && we && !duplex_active && !dec_fault) |-> $countones(bank_we) == 1);
  // R2: a valid mirrored write touches exactly two modules
  p_duplex_two_banks_r2: assert property (@(posedge clk) disable iff (rst)
    (req && we && duplex_active && !dec_fault) |-> $countones(bank_we) == 2);
  // R8: a faulted address writes nothing
  p_fault_no_write_r8: assert property (@(posedge clk) disable iff (rst)
    dec_fault |-> bank_we == '0);
  // R9: the mode changes only after an idle edge
  p_mode_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(duplex_active) |-> $past(!req && !s1_v));
  // R10: fixed two-edge response latency
  p_latency_r10: assert property (@(posedge clk) disable iff (rst)
    req |=> ##1 rsp_valid);
endmodule

// File: tb/mirror_mem_mgr_test.sv
module mirror_mem_mgr_test;
  localparam int NM = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_duplex = 1'b0, req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [25:0] wdata = '0;
  logic [1:0]  wr_par_inv = '0;
  logic        rsp_valid, rsp_fault, err_corr, err_uncorr, duplex_active;
  logic [25:0] rd_data;

  int checks = 0, errors = 0;
  logic mode_m = 1'b0;
  logic [27:0] ref_mem [8][512];

  always #5 clk = ~clk;

  mirror_mem_mgr uut (
    .clk(clk), .rst(rst), .cfg_duplex(cfg_duplex), .req(req), .we(we),
    .addr(addr), .wdata(wdata), .wr_par_inv(wr_par_inv),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rd_data(rd_data),
    .err_corr(err_corr), .err_uncorr(err_uncorr), .duplex_active(duplex_active)
  );

  function automatic logic [27:0] b_enc(input logic [25:0] d, input logic [1:0] inv);
    logic pl, ph;
    pl = 1'b1;
    ph = 1'b1;
    for (int i = 0; i < 13; i++) begin
      pl = pl ^ d[i];
      ph = ph ^ d[13+i];
    end
    return {ph ^ inv[1], d[25:13], pl ^ inv[0], d[12:0]};
  endfunction

  function automatic logic b_ok(input logic [27:0] c);
    return ($countones(c[13:0]) % 2 == 1) && ($countones(c[27:14]) % 2 == 1);
  endfunction

  function automatic logic [25:0] b_pay(input logic [27:0] c);
    return {c[26:14], c[12:0]};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model: expected {fault, corr, uncorr, data}; applies writes to ref_mem
  task automatic model(input logic w, input logic [11:0] a, input logic [25:0] d,
                       input logic [1:0] inv, output logic [28:0] exp);
    int mi;
    logic f;
    logic [27:0] p, s;
    mi = mode_m ? (int'(a[10:9]) * 2) : int'(a[11:9]);
    f = mode_m ? (a[11] || (mi + 1 >= NM)) : (mi >= NM);
    exp = '0;
    if (f) exp[28] = 1'b1;
    else if (w) begin
      ref_mem[mi][a[8:0]] = b_enc(d, inv);
      if (mode_m) ref_mem[mi+1][a[8:0]] = b_enc(d, inv);
    end else begin
      p = ref_mem[mi][a[8:0]];
      if (!mode_m) exp = {1'b0, 1'b0, !b_ok(p), b_pay(p)};
      else begin
        s = ref_mem[mi+1][a[8:0]];
        if (b_ok(p))      exp = {3'b000, b_pay(p)};
        else if (b_ok(s)) exp = {3'b010, b_pay(s)};
        else              exp = {3'b001, b_pay(p)};
      end
    end
  endtask

  task automatic do_op(input logic w, input logic [11:0] a, input logic [25:0] d,
                       input logic [1:0] inv, input string tag);
    logic [28:0] exp;
    model(w, a, d, inv, exp);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d; wr_par_inv = inv;
    @(negedge clk);
    req = 1'b0; we = 1'b0; wr_par_inv = '0;
    chk({tag, " no early rsp"}, {63'd0, rsp_valid}, 64'd0);
    @(negedge clk);
    chk(tag, {34'd0, rsp_valid, rsp_fault, err_corr, err_uncorr, rd_data},
             {34'd0, 1'b1, exp[28], exp[27], exp[26], exp[25:0]});
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk);
    cfg_duplex = m;
    @(negedge clk);
    mode_m = m;
    chk("R9 mode applied when idle", {63'd0, duplex_active}, {63'd0, m});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [28:0] e;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 reset outputs", {35'd0, rsp_valid, rsp_fault, err_corr, err_uncorr, duplex_active, rd_data},
        64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 simplex after reset", {63'd0, duplex_active}, 64'd0);

    // preload word window 0..15 of every module in single-copy mode
    for (int m = 0; m < NM; m++)
      for (int w = 0; w < 16; w++)
        do_op(1'b1, {m[2:0], w[8:0]}, 26'($urandom), 2'b00, "R10 preload write");

    // R1 single-copy write/read
    do_op(1'b1, {3'd0, 9'd20}, 26'h2AB_CDEF & 26'h3FF_FFFF, 2'b00, "R1 write m0");
    do_op(1'b1, {3'd5, 9'd20}, 26'h155_1234, 2'b00, "R1 write m5");
    do_op(1'b0, {3'd0, 9'd20}, '0, 2'b00, "R1 read m0");
    do_op(1'b0, {3'd5, 9'd20}, '0, 2'b00, "R1 read m5");
    // R8 single-copy fault, module 6
    do_op(1'b1, {3'd6, 9'd20}, 26'h3FF_FFFF, 2'b00, "R8 simplex fault write");
    do_op(1'b0, {3'd7, 9'd20}, '0, 2'b00, "R8 simplex fault read");
    // R7 / R3 parity failures in either syllable
    do_op(1'b1, {3'd2, 9'd21}, 26'h0AA_5555, 2'b01, "R3 write lo inverted");
    do_op(1'b0, {3'd2, 9'd21}, '0, 2'b00, "R7 simplex lo parity fail");
    do_op(1'b1, {3'd2, 9'd22}, 26'h123_4567, 2'b10, "R3 write hi inverted");
    do_op(1'b0, {3'd2, 9'd22}, '0, 2'b00, "R3 hi parity fail marks copy bad");

    // diverging copies at word 5 of pair 0
    do_op(1'b1, {3'd0, 9'd5}, 26'h111_1111, 2'b01, "R5 setup primary bad");
    do_op(1'b1, {3'd1, 9'd5}, 26'h222_2222, 2'b00, "R5 setup secondary good");
    do_op(1'b1, {3'd0, 9'd6}, 26'h033_3333, 2'b10, "R6 setup primary bad");
    do_op(1'b1, {3'd1, 9'd6}, 26'h044_4444, 2'b11, "R6 setup secondary bad");
    do_op(1'b1, {3'd0, 9'd7}, 26'h155_5555, 2'b00, "R4 setup primary good");
    do_op(1'b1, {3'd1, 9'd7}, 26'h266_6666, 2'b01, "R4 setup secondary bad");

    // R9 mode request during an access is held
    model(1'b0, {3'd0, 9'd20}, '0, 2'b00, e);
    @(negedge clk);
    cfg_duplex = 1'b1; req = 1'b1; we = 1'b0; addr = {3'd0, 9'd20};
    @(negedge clk);
    req = 1'b0;
    chk("R9 held while request present", {63'd0, duplex_active}, 64'd0);
    @(negedge clk);
    chk("R9 held while access in flight", {63'd0, duplex_active}, 64'd0);
    chk("R9 in-flight access decoded single-copy",
        {35'd0, rsp_valid, rsp_fault, err_corr, err_uncorr, rd_data},
        {35'd0, 1'b1, e[28], e[27], e[26], e[25:0]});
    @(negedge clk);
    mode_m = 1'b1;
    chk("R9 applied after access", {63'd0, duplex_active}, 64'd1);

    do_op(1'b0, {3'd0, 9'd5}, '0, 2'b00, "R5 secondary substituted");
    do_op(1'b0, {3'd0, 9'd6}, '0, 2'b00, "R6 both copies bad");
    do_op(1'b0, {3'd0, 9'd7}, '0, 2'b00, "R4 primary good");
    // R2 mirrored write reaches both modules
    do_op(1'b1, {3'd1, 9'd9}, 26'h3C3_C3C3, 2'b00, "R10 mirrored write rsp");
    do_op(1'b0, {3'd1, 9'd9}, '0, 2'b00, "R2 mirrored read");
    // R8 mirrored faults: bit 11 set (would alias pair 0), pair 3 unpopulated
    do_op(1'b1, {3'd4, 9'd7}, 26'h3FF_0000, 2'b00, "R8 duplex bit11 fault");
    do_op(1'b1, {3'd3, 9'd7}, 26'h3FF_0000, 2'b00, "R8 duplex pair3 fault");
    do_op(1'b0, {3'd0, 9'd7}, '0, 2'b00, "R8 pair0 unchanged after fault");
    set_mode(1'b0);
    do_op(1'b0, {3'd2, 9'd9}, '0, 2'b00, "R2 copy in module 2");
    do_op(1'b0, {3'd3, 9'd9}, '0, 2'b00, "R2 copy in module 3");

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      logic [11:0] a;
      logic [1:0] inv;
      if ($urandom % 16 == 0) set_mode(~mode_m);
      a = {3'($urandom), 5'd0, 4'($urandom)};
      inv = ($urandom % 4 == 0) ? 2'($urandom) : 2'b00;
      do_op(1'($urandom), a, 26'($urandom), inv, "R10 random access");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule